// File: doc/BRIEF.md
# Three-channel compare timer

This block is an up-counter with a register port. It is usually used as a periodic or one-shot event source. A 3-bit source field in the control register picks which tick strobe drives it: the fast peripheral tick, the slow tick, or nothing. A 12-bit prescaler divides the chosen strobe. Every prescaled step advances the counter by one.

Three compare registers watch the counter, and each one raises its own sticky flag. In restart mode, compare channel 1 also sets the counting period. In free-run mode the counter runs through all compare values and wraps at all-ones, which raises a rollover flag. Software clears flags by writing ones to them. The single level interrupt output combines the flags with an enable mask. A soft-reset bit in the control register returns the block to its idle state in one write.

Counting is governed by a two-state machine:
- **HALT**: the counter holds its value and the interrupt output is low.
- **COUNT**: each prescaled step advances the counter.

It has two transitions:
- **HALT to COUNT (enable)**: a control write with the enable bit set and the soft-reset bit clear. If the restart-on-enable bit is set in that write, the counter and prescaler clear. Otherwise the counter resumes from its held value.
- **COUNT to HALT (disable)**: a control write with the enable bit clear or the soft-reset bit set.

Top module: `cmp_timer`

## Requirements
- R1: The word index is byte address >> 2. Indices 0 to 9 map to control, prescaler, status, interrupt enable, compare 1, compare 2, compare 3, capture 1, capture 2 and counter, in that order. The capture registers and any index above 9 read zero, and writes to them change nothing.
- R2: Control bits [8:6] select the tick source: 001 or 010 selects `tick_main`, 100 selects `tick_slow`, and every other code selects no source, so the counter stays still.
- R3: The prescaler register keeps bits [11:0] of a write. While counting, the counter advances once every (prescaler+1) ticks of the selected source.
- R4: A control write never stores bits in mask 0x7C14 or bit 15 (soft reset). Bit 0 (enable) reads back 1 exactly while the state is COUNT.
- R5: Status bits [5:0] are write-one-to-clear, and writing 0 to a bit leaves it unchanged. The interrupt enable register stores bits [5:0] of a write.
- R6: `irq` is high exactly when the state is COUNT and (status & interrupt enable) is nonzero.
- R7: When the counter steps onto the value of compare 1, 2 or 3, status bit 0, 1 or 2 respectively is set in the same clock.
- R8: A step from the all-ones counter value to zero sets status bit 5 (rollover).
- R9: With control bit 9 clear (restart mode), the step after the counter equals compare 1 reloads it to zero. A write to compare 1 in this mode clears the counter.
- R10: With control bit 9 set (free-run mode), the counter keeps incrementing past compare matches.
- R11: A control write with bit 15 set clears control bits [5:0] of the written value and stores the rest. The same write zeroes status, prescaler, interrupt enable and counter, and sets all three compares to all-ones.
- R12: Enabling with control bit 1 set restarts the counter from zero. Enabling without it resumes from the held value. Disabling freezes the counter.
- R13: After `rst_n` the control, status, prescaler, interrupt enable and counter registers read zero, all three compares read all-ones, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_main | input | 1 | Fast peripheral tick strobe, one cycle per tick |
| tick_slow | input | 1 | Slow tick strobe, one cycle per tick |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
A wrong run state shows at the ports as `irq` staying high after a disable. It also shows as the counter moving while enable reads 0, and either symptom is visible on the next tick. A wrong prescaler or reload state puts the counter read off by one step within (prescaler+1) ticks of the fault, and the compare flags then land in the wrong step. Lost or spurious status bits appear at once on the status read and on `irq` whenever the matching interrupt enable is set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int FLAG_W    = 6;
    localparam int NUM_CMP   = 3;
    localparam int REG_COUNT = 10;

    localparam logic [3:0] IDX_CTRL = 4'd0;
    localparam logic [3:0] IDX_PSC  = 4'd1;
    localparam logic [3:0] IDX_STAT = 4'd2;
    localparam logic [3:0] IDX_IEN  = 4'd3;
    localparam logic [3:0] IDX_CMP1 = 4'd4;
    localparam logic [3:0] IDX_CMP2 = 4'd5;
    localparam logic [3:0] IDX_CMP3 = 4'd6;
    localparam logic [3:0] IDX_CNT  = 4'd9;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_RSTEN = 1;
    localparam int CTRL_SRC   = 6;
    localparam int CTRL_FREE  = 9;
    localparam int CTRL_SOFT  = 15;

    localparam logic [31:0] CTRL_DROP_M = 32'h0000_7C14;
    localparam logic [31:0] CTRL_SOFT_M = 32'h0000_8000;
    localparam logic [31:0] CTRL_EN_M   = 32'h0000_0001;
    localparam logic [31:0] CTRL_LOW_M  = 32'h0000_003F;

    localparam int FLG_ROLL = 5;

    typedef enum logic {
        RUN_HALT  = 1'b0,
        RUN_COUNT = 1'b1
    } run_state_e;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [2:0]       src,
    input  logic             tick_main,
    input  logic             tick_slow,
    input  logic [PSC_W-1:0] psc,
    output logic             step
);

    logic             sel_tick;
    logic             live;
    logic [PSC_W-1:0] div_q;

    always_comb begin
        unique case (src)
            3'b001, 3'b010: sel_tick = tick_main;
            3'b100:         sel_tick = tick_slow;
            default:        sel_tick = 1'b0;
        endcase
    end

    assign live = run && sel_tick;
    // ">=" lets a lowered prescaler take effect at once
    assign step = live && (div_q >= psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr || step) begin
            div_q <= '0;
        end else if (live) begin
            div_q <= div_q + PSC_W'(1);
        end
    end

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CNT_W = 32,
    parameter int NUM   = 3
) (
    input  logic                      step,
    input  logic [CNT_W-1:0]          cnt_next,
    input  logic [NUM-1:0][CNT_W-1:0] ocr,
    output logic [NUM-1:0]            hit
);

    for (genvar g = 0; g < NUM; g++) begin : g_ch
        assign hit[g] = step && (cnt_next == ocr[g]);
    end

endmodule

// File: rtl/tmr_run_ctl.sv
module tmr_run_ctl
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_en,
    input  logic wr_rsten,
    input  logic wr_soft,
    output logic running,
    output logic restart
);

    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALT:  if (ctrl_wr && !wr_soft && wr_en) state_d = RUN_COUNT;
            RUN_COUNT: if (ctrl_wr && (wr_soft || !wr_en)) state_d = RUN_HALT;
            default:   state_d = RUN_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == RUN_COUNT);
        restart = (state_q == RUN_HALT) && ctrl_wr && !wr_soft && wr_en && wr_rsten;
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 12,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_main,
    input  logic              tick_slow,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [31:0]                  ctrl_q;
    logic [PSC_W-1:0]             psc_q;
    logic [FLAG_W-1:0]            stat_q;
    logic [FLAG_W-1:0]            ien_q;
    logic [NUM_CMP-1:0][CNT_W-1:0] ocr_q;
    logic [CNT_W-1:0]             cnt_q;

    logic [WIDX_W-1:0] widx;
    logic [3:0]        ridx;
    logic              in_map;
    logic              wr;
    logic              ctrl_wr, psc_wr, stat_wr, ien_wr;
    logic [NUM_CMP-1:0] ocr_wr;
    logic              soft_wr;
    logic              unused_lo;

    logic              running, restart;
    logic              step, step_eff;
    logic              free_run;
    logic              cnt_max, reload, ocr1_clr, cnt_clr;
    logic [CNT_W-1:0]  step_val;
    logic [NUM_CMP-1:0] hit;
    logic [FLAG_W-1:0] flag_set;

    // address decode
    assign widx      = bus_addr[ADDR_W-1:2];
    assign unused_lo = ^bus_addr[1:0];
    assign in_map    = (widx < WIDX_W'(REG_COUNT));
    assign ridx      = in_map ? widx[3:0] : 4'hF;
    assign wr        = bus_valid && bus_write && in_map;
    assign ctrl_wr   = wr && (ridx == IDX_CTRL);
    assign psc_wr    = wr && (ridx == IDX_PSC);
    assign stat_wr   = wr && (ridx == IDX_STAT);
    assign ien_wr    = wr && (ridx == IDX_IEN);
    assign soft_wr   = ctrl_wr && bus_wdata[CTRL_SOFT];

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_ocr_wr
        assign ocr_wr[g] = wr && (ridx == IDX_CMP1 + 4'(g));
    end

    tmr_run_ctl u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wr_en    (bus_wdata[CTRL_EN]),
        .wr_rsten (bus_wdata[CTRL_RSTEN]),
        .wr_soft  (bus_wdata[CTRL_SOFT]),
        .running  (running),
        .restart  (restart)
    );

    assign free_run = ctrl_q[CTRL_FREE];
    assign ocr1_clr = ocr_wr[0] && !free_run;
    assign cnt_clr  = soft_wr || restart || ocr1_clr;

    tmr_tick_gen #(.PSC_W(PSC_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .clr       (cnt_clr),
        .src       (ctrl_q[CTRL_SRC+2:CTRL_SRC]),
        .tick_main (tick_main),
        .tick_slow (tick_slow),
        .psc       (psc_q),
        .step      (step)
    );

    // counter next value
    assign cnt_max  = (cnt_q == '1);
    assign reload   = !free_run && (cnt_q == ocr_q[0]);
    assign step_val = (reload || cnt_max) ? '0 : cnt_q + CNT_W'(1);
    assign step_eff = step && !cnt_clr;

    tmr_compare #(.CNT_W(CNT_W), .NUM(NUM_CMP)) u_cmp (
        .step     (step_eff),
        .cnt_next (step_val),
        .ocr      (ocr_q),
        .hit      (hit)
    );

    always_comb begin
        flag_set             = '0;
        flag_set[NUM_CMP-1:0] = hit;
        flag_set[FLG_ROLL]   = step_eff && cnt_max;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            psc_q  <= '0;
            stat_q <= '0;
            ien_q  <= '0;
            ocr_q  <= '1;
            cnt_q  <= '0;
        end else if (soft_wr) begin
            ctrl_q <= bus_wdata & ~(CTRL_DROP_M | CTRL_SOFT_M | CTRL_LOW_M);
            psc_q  <= '0;
            stat_q <= '0;
            ien_q  <= '0;
            ocr_q  <= '1;
            cnt_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= bus_wdata & ~(CTRL_DROP_M | CTRL_SOFT_M | CTRL_EN_M);
            if (psc_wr)  psc_q  <= bus_wdata[PSC_W-1:0];
            if (ien_wr)  ien_q  <= bus_wdata[FLAG_W-1:0];
            stat_q <= (stat_q & ~(stat_wr ? bus_wdata[FLAG_W-1:0] : '0)) | flag_set;
            for (int i = 0; i < NUM_CMP; i++) begin
                if (ocr_wr[i]) ocr_q[i] <= bus_wdata[CNT_W-1:0];
            end
            if (cnt_clr)       cnt_q <= '0;
            else if (step_eff) cnt_q <= step_val;
        end
    end

    assign irq = running && ((stat_q & ien_q) != '0);

    always_comb begin
        unique case (ridx)
            IDX_CTRL: bus_rdata = ctrl_q | {31'd0, running};
            IDX_PSC:  bus_rdata = 32'(psc_q);
            IDX_STAT: bus_rdata = 32'(stat_q);
            IDX_IEN:  bus_rdata = 32'(ien_q);
            IDX_CMP1: bus_rdata = 32'(ocr_q[0]);
            IDX_CMP2: bus_rdata = 32'(ocr_q[1]);
            IDX_CMP3: bus_rdata = 32'(ocr_q[2]);
            IDX_CNT:  bus_rdata = 32'(cnt_q);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic             irq,
    input logic             running,
    input logic [CNT_W-1:0] cnt_q,
    input logic [5:0]       stat_q
);

    logic any_wr;
    assign any_wr = bus_valid && bus_write;

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> running);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(any_wr) && (cnt_q != $past(cnt_q)))
            |-> ((cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))) || (cnt_q == '0)));

    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(running) && !$past(any_wr)) |-> $stable(cnt_q));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(any_wr) |-> (($past(stat_q) & ~stat_q) == 6'd0));

    assert_roll_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(any_wr) && ($past(cnt_q) == '1) && (cnt_q == '0)) |-> stat_q[5]);

endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .irq       (irq),
    .running   (running),
    .cnt_q     (cnt_q),
    .stat_q    (stat_q)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 12;
    localparam logic [31:0] ONES = 32'h0000_00FF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_main = 1'b0;
    logic              tick_slow = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmp_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_main (tick_main),
        .tick_slow (tick_slow),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr  = ADDR_W'(idx * 4);
        bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] data);
        bus_valid = 1'b1; bus_write = 1'b0;
        bus_addr  = ADDR_W'(idx * 4);
        #1;
        data = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic chk_reg(input string req, input string what, input int idx,
                           input logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        check(req, what, v, exp);
    endtask

    task automatic ticks(input bit slow, input int n);
        @(negedge clk);
        if (slow) tick_slow = 1'b1; else tick_main = 1'b1;
        repeat (n) @(negedge clk);
        tick_slow = 1'b0; tick_main = 1'b0;
    endtask

    task automatic soft_reset();
        wr(0, 32'h0000_8000);
    endtask

    task automatic t_hard_reset();
        chk_reg("R13", "ctrl", 0, 32'h0);
        chk_reg("R13", "psc", 1, 32'h0);
        chk_reg("R13", "stat", 2, 32'h0);
        chk_reg("R13", "ien", 3, 32'h0);
        chk_reg("R13", "cmp1", 4, ONES);
        chk_reg("R13", "cmp2", 5, ONES);
        chk_reg("R13", "cmp3", 6, ONES);
        chk_reg("R13", "cnt", 9, 32'h0);
        check("R13", "irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_map();
        wr(12, 32'h55);
        chk_reg("R1", "unmapped read", 12, 32'h0);
        wr(7, 32'h12);
        chk_reg("R1", "capture1 read", 7, 32'h0);
        chk_reg("R1", "capture2 read", 8, 32'h0);
        chk_reg("R1", "cmp1 untouched", 4, ONES);
        chk_reg("R1", "ctrl untouched", 0, 32'h0);
    endtask

    task automatic t_ctrl_mask();
        wr(0, 32'h0000_7FFF);
        chk_reg("R4", "ctrl mask readback", 0, 32'h0000_03EB);
        ticks(0, 5);
        ticks(1, 5);
        chk_reg("R2", "no source holds cnt", 9, 32'h0);
        soft_reset();
    endtask

    task automatic t_prescale();
        wr(1, 32'hFFFF_F002);
        chk_reg("R3", "psc keeps 12 bits", 1, 32'h002);
        wr(0, 32'h0000_0241);
        ticks(0, 6);
        chk_reg("R3", "six ticks div3", 9, 32'd2);
        ticks(1, 6);
        chk_reg("R2", "slow ignored on 001", 9, 32'd2);
        wr(0, 32'h0000_0301);
        ticks(1, 3);
        chk_reg("R2", "slow source 100", 9, 32'd3);
        wr(0, 32'h0000_0281);
        ticks(0, 3);
        chk_reg("R2", "main source 010", 9, 32'd4);
        soft_reset();
    endtask

    task automatic t_free_compare();
        wr(4, 32'd3);
        wr(5, 32'd5);
        wr(6, 32'd5);
        wr(0, 32'h0000_0241);
        ticks(0, 3);
        chk_reg("R7", "cnt at cmp1", 9, 32'd3);
        chk_reg("R7", "flag0 on cmp1", 2, 32'h01);
        ticks(0, 2);
        chk_reg("R7", "flags on cmp2 cmp3", 2, 32'h07);
        check("R6", "irq masked", {31'd0, irq}, 32'h0);
        ticks(0, 1);
        chk_reg("R10", "free run past cmp", 9, 32'd6);
        wr(3, 32'hFFFF_FFFF);
        chk_reg("R5", "ien 6 bits", 3, 32'h3F);
        check("R6", "irq raised", {31'd0, irq}, 32'h1);
        wr(2, 32'h02);
        chk_reg("R5", "w1c clears bit1", 2, 32'h05);
        wr(2, 32'h00);
        chk_reg("R5", "zero write keeps", 2, 32'h05);
        wr(0, 32'h0000_0240);
        check("R6", "irq low when halted", {31'd0, irq}, 32'h0);
        ticks(0, 3);
        chk_reg("R12", "halt freezes cnt", 9, 32'd6);
        wr(0, 32'h0000_0241);
        ticks(0, 1);
        chk_reg("R12", "resume from held", 9, 32'd7);
        wr(0, 32'h0000_0240);
        wr(0, 32'h0000_0243);
        chk_reg("R12", "restart on enable", 9, 32'd0);
        chk_reg("R4", "enable reads 1", 0, 32'h0000_0243);
        soft_reset();
    endtask

    task automatic t_restart();
        wr(4, 32'd4);
        wr(0, 32'h0000_0041);
        ticks(0, 4);
        chk_reg("R9", "cnt at cmp1", 9, 32'd4);
        chk_reg("R7", "flag0 restart mode", 2, 32'h01);
        ticks(0, 1);
        chk_reg("R9", "reload to zero", 9, 32'd0);
        ticks(0, 2);
        chk_reg("R9", "counting again", 9, 32'd2);
        wr(4, 32'd10);
        chk_reg("R9", "cmp1 write clears", 9, 32'd0);
        ticks(0, 3);
        chk_reg("R9", "after clear", 9, 32'd3);
        soft_reset();
    endtask

    task automatic t_rollover();
        wr(3, 32'h20);
        wr(0, 32'h0000_0241);
        ticks(0, 255);
        chk_reg("R8", "cnt at all-ones", 9, ONES);
        chk_reg("R8", "cmp flags only", 2, 32'h07);
        check("R8", "irq before wrap", {31'd0, irq}, 32'h0);
        ticks(0, 1);
        chk_reg("R8", "cnt wrapped", 9, 32'd0);
        chk_reg("R8", "rollover flag", 2, 32'h27);
        check("R8", "irq on rollover", {31'd0, irq}, 32'h1);
        soft_reset();
    endtask

    task automatic t_soft();
        wr(0, 32'h0000_0243);
        wr(1, 32'd5);
        wr(3, 32'h3F);
        wr(5, 32'd7);
        ticks(0, 12);
        chk_reg("R3", "div6 count", 9, 32'd2);
        wr(0, 32'h0001_8243);
        chk_reg("R11", "ctrl after soft", 0, 32'h0001_0240);
        chk_reg("R11", "stat", 2, 32'h0);
        chk_reg("R11", "psc", 1, 32'h0);
        chk_reg("R11", "ien", 3, 32'h0);
        chk_reg("R11", "cnt", 9, 32'h0);
        chk_reg("R11", "cmp1", 4, ONES);
        chk_reg("R11", "cmp2", 5, ONES);
        chk_reg("R11", "cmp3", 6, ONES);
        check("R11", "irq", {31'd0, irq}, 32'h0);
        ticks(0, 3);
        chk_reg("R11", "halted after soft", 9, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_hard_reset();
        t_map();
        t_ctrl_mask();
        t_prescale();
        t_free_compare();
        t_restart();
        t_rollover();
        t_soft();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule